// File: doc/BRIEF.md
# Multilevel Modulation Mode Supervisor

This block chooses, for a multilevel inverter modulator, between level-shifted carrier PWM and a capacitor-balancing space-vector mode. It watches the measured DC-link capacitor unbalance and the commanded modulation depth. It changes mode only on the strobe that marks the end of a carrier period, so the switch never cuts a period short. The block enters space-vector mode when the unbalance rises above a programmable limit. It leaves that mode only once the unbalance is back within the limit and the modulation depth has fallen to a return threshold. That threshold is lower for heavy loads than for light loads, which gives the mode choice a load-dependent hysteresis.

While in space-vector mode, the block also tracks which of the 18 triangular regions of the vector plane holds the reference. It offers the region-finding logic a mask of candidate regions, so only the current region and its three forward neighbours need to be tested. When the region is unknown, the mask covers all 18 regions. This is the case after reset, after leaving space-vector mode, or after a sample lands outside the candidates. A configuration check flags an unbalance limit that is not above the largest unbalance that redundant state selection can correct in PWM mode.

Top module: `modsel_supervisor`

## Requirements
- R1: After reset, mode_sv is 0 (carrier PWM), region_known is 0, cur_region is 0 and cand_mask is all ones.
- R2: mode_sv changes only at a clock edge where period_end is 1; at other edges it holds.
- R3: In PWM mode, an edge with period_end=1 and unbal > unbal_limit sets mode_sv to 1; with unbal <= unbal_limit it stays 0.
- R4: In space-vector mode with heavy_load=1, an edge with period_end=1 returns mode_sv to 0 exactly when unbal <= unbal_limit and depth <= RET_HEAVY (default 172, i.e. 0.67 in Q2.8).
- R5: In space-vector mode with heavy_load=0, the same return happens exactly when unbal <= unbal_limit and depth <= RET_LIGHT (default 197, i.e. 0.77 in Q2.8).
- R6: In space-vector mode, an edge with period_end=1 and unbal > unbal_limit keeps mode_sv at 1 whatever the depth.
- R7: cfg_err is 1 exactly when unbal_limit <= redund_cap, combinationally.
- R8: Regions are numbered 1 to 18, and region r corresponds to cand_mask bit r-1. While region_known is 0, cand_mask is all ones.
- R9: While region_known is 1, cand_mask has exactly four bits set. For an inner region k (1..12), these are k, (k mod 12)+1, 13+((k-1) div 2) and 13+(((k+1) div 2) mod 6). For an outer region 13+j (j = 0..5), these are 13+j, 13+((j+1) mod 6), 2j+2 and ((2j+2) mod 12)+1. The candidates for region 1 are therefore 1, 2, 13 and 14.
- R10: In space-vector mode, an sv_tick with found_region in 1..18 and inside cand_mask loads cur_region with found_region and sets region_known at the next edge. Any other found_region value clears region_known and leaves cur_region unchanged.
- R11: In PWM mode, sv_tick has no effect on cur_region and region_known is 0. After a return to PWM, the region stays unknown until a new valid sample arrives in space-vector mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_end | input | 1 | End-of-carrier-period strobe |
| sv_tick | input | 1 | Space-vector computation strobe, qualifies found_region |
| unbal | input | UNB_W | Capacitor unbalance magnitude, 0.1 % steps |
| unbal_limit | input | UNB_W | Unbalance limit that triggers space-vector mode |
| redund_cap | input | UNB_W | Largest unbalance PWM redundancy can correct |
| depth | input | DEPTH_W | Modulation depth, unsigned Q2.8 |
| heavy_load | input | 1 | 1 selects the heavy-load return threshold |
| found_region | input | REG_W | Region reported by the region-finding logic |
| mode_sv | output | 1 | 1 = space-vector mode, 0 = carrier PWM |
| cfg_err | output | 1 | Limit not above the redundancy capability |
| region_known | output | 1 | Tracked region is valid |
| cur_region | output | REG_W | Last accepted region index |
| cand_mask | output | INNER_REGIONS+OUTER_REGIONS | Regions to test on the next sample |

## Verification
The mode decision is swept over a grid of depth values around both return thresholds, three unbalance values around the limit (one below, equal, one above) and both load flags. Each point is started from both modes. This separates a strict from a non-strict comparison on every threshold, and it separates the heavy-load threshold from the light-load threshold. The same points with period_end low show that the mode is held between strobes. The tracker is swept over every pair of current region and reported region. This compares the full neighbour mask for each region and separates accepted samples from rejected ones. Out-of-range codes and ticks in PWM mode cover the cases where the region is lost or ignored.

// File: rtl/modsel_pkg.sv
package modsel_pkg;

   // Candidate set for region r (1-based): itself plus three forward neighbours.
   function automatic logic [31:0] nbr_mask(input int r, input int inner, input int outer);
      logic [31:0] m;
      int j;
      m = '0;
      if (r >= 1 && r <= inner) begin
         m |= 32'd1 << (r - 1);
         m |= 32'd1 << ((r % inner));
         m |= 32'd1 << (inner + ((r - 1) >> 1));
         m |= 32'd1 << (inner + (((r + 1) >> 1) % outer));
      end else if (r > inner && r <= inner + outer) begin
         j = r - inner - 1;
         m |= 32'd1 << (r - 1);
         m |= 32'd1 << (inner + ((j + 1) % outer));
         m |= 32'd1 << (2 * j + 1);
         m |= 32'd1 << ((2 * j + 2) % inner);
      end
      return m;
   endfunction

endpackage

// File: rtl/modsel_mode_fsm.sv
module modsel_mode_fsm #(
   parameter int UNB_W     = 8,
   parameter int DEPTH_W   = 10,
   parameter int RET_HEAVY = 172,
   parameter int RET_LIGHT = 197
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               period_end,
   input  logic [UNB_W-1:0]   unbal,
   input  logic [UNB_W-1:0]   unbal_limit,
   input  logic [DEPTH_W-1:0] depth,
   input  logic               heavy_load,
   output logic               mode_sv
);
   localparam logic [DEPTH_W-1:0] THR_H = DEPTH_W'(RET_HEAVY);
   localparam logic [DEPTH_W-1:0] THR_L = DEPTH_W'(RET_LIGHT);

   logic over_lim;
   logic depth_ok;
   logic mode_nxt;

   always_comb begin
      over_lim = (unbal > unbal_limit);
      depth_ok = heavy_load ? (depth <= THR_H) : (depth <= THR_L);
      if (!mode_sv) mode_nxt = over_lim;
      else          mode_nxt = !(!over_lim && depth_ok);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          mode_sv <= 1'b0;
      else if (period_end) mode_sv <= mode_nxt;
   end
endmodule

// File: rtl/modsel_nbr_rom.sv
module modsel_nbr_rom #(
   parameter int INNER = 12,
   parameter int OUTER = 6,
   parameter int REG_W = 5,
   localparam int NREG = INNER + OUTER
) (
   input  logic [REG_W-1:0] region,
   output logic [NREG-1:0]  mask
);
   import modsel_pkg::*;

   logic [NREG-1:0] tbl [NREG+1];

   for (genvar g = 0; g <= NREG; g++) begin : g_ent
      if (g == 0) begin : g_none
         assign tbl[g] = '1;
      end else begin : g_reg
         localparam logic [31:0] M = nbr_mask(g, INNER, OUTER);
         assign tbl[g] = M[NREG-1:0];
      end
   end

   always_comb begin
      if (region <= REG_W'(NREG)) mask = tbl[region];
      else                        mask = '1;
   end
endmodule

// File: rtl/modsel_region_tracker.sv
module modsel_region_tracker #(
   parameter int INNER = 12,
   parameter int OUTER = 6,
   parameter int REG_W = 5,
   localparam int NREG = INNER + OUTER
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_sv,
   input  logic             sv_tick,
   input  logic [REG_W-1:0] found_region,
   output logic             region_known,
   output logic [REG_W-1:0] cur_region,
   output logic [NREG-1:0]  cand_mask
);
   logic             known_q;
   logic [NREG-1:0]  rom_mask;
   logic             in_range;
   logic             hit;
   logic [NREG-1:0]  sel;

   modsel_nbr_rom #(.INNER(INNER), .OUTER(OUTER), .REG_W(REG_W)) u_rom (
      .region (cur_region),
      .mask   (rom_mask)
   );

   always_comb begin
      region_known = known_q & mode_sv;
      cand_mask    = region_known ? rom_mask : '1;
      in_range     = (found_region >= REG_W'(1)) && (found_region <= REG_W'(NREG));
      sel          = in_range ? (NREG'(1) << (found_region - REG_W'(1))) : '0;
      hit          = in_range && ((cand_mask & sel) != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         known_q    <= 1'b0;
         cur_region <= '0;
      end else if (!mode_sv) begin
         known_q    <= 1'b0;
      end else if (sv_tick) begin
         known_q    <= hit;
         if (hit) cur_region <= found_region;
      end
   end
endmodule

// File: rtl/modsel_supervisor.sv
module modsel_supervisor #(
   parameter int UNB_W         = 8,
   parameter int DEPTH_W       = 10,
   parameter int RET_HEAVY     = 172,
   parameter int RET_LIGHT     = 197,
   parameter int INNER_REGIONS = 12,
   parameter int OUTER_REGIONS = 6,
   parameter int REG_W         = 5
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   period_end,
   input  logic                                   sv_tick,
   input  logic [UNB_W-1:0]                       unbal,
   input  logic [UNB_W-1:0]                       unbal_limit,
   input  logic [UNB_W-1:0]                       redund_cap,
   input  logic [DEPTH_W-1:0]                     depth,
   input  logic                                   heavy_load,
   input  logic [REG_W-1:0]                       found_region,
   output logic                                   mode_sv,
   output logic                                   cfg_err,
   output logic                                   region_known,
   output logic [REG_W-1:0]                       cur_region,
   output logic [INNER_REGIONS+OUTER_REGIONS-1:0] cand_mask
);
   localparam int NREG = INNER_REGIONS + OUTER_REGIONS;

   if (INNER_REGIONS != 2 * OUTER_REGIONS) begin : g_bad_ring
      $error("inner ring must hold twice the outer regions");
   end
   if (NREG > 32 || (1 << REG_W) <= NREG) begin : g_bad_w
      $error("region index width too small or region count too large");
   end
   if (RET_HEAVY > RET_LIGHT || RET_LIGHT >= (1 << DEPTH_W)) begin : g_bad_thr
      $error("return thresholds out of order or range");
   end

   assign cfg_err = (unbal_limit <= redund_cap);

   modsel_mode_fsm #(
      .UNB_W(UNB_W), .DEPTH_W(DEPTH_W), .RET_HEAVY(RET_HEAVY), .RET_LIGHT(RET_LIGHT)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .period_end(period_end), .unbal(unbal),
      .unbal_limit(unbal_limit), .depth(depth), .heavy_load(heavy_load),
      .mode_sv(mode_sv)
   );

   modsel_region_tracker #(
      .INNER(INNER_REGIONS), .OUTER(OUTER_REGIONS), .REG_W(REG_W)
   ) u_trk (
      .clk(clk), .rst_n(rst_n), .mode_sv(mode_sv), .sv_tick(sv_tick),
      .found_region(found_region), .region_known(region_known),
      .cur_region(cur_region), .cand_mask(cand_mask)
   );
endmodule

// File: rtl/modsel_supervisor_chk.sv
module modsel_supervisor_chk #(
   parameter int UNB_W   = 8,
   parameter int DEPTH_W = 10,
   parameter int REG_W   = 5,
   parameter int NREG    = 18
) (
   input logic               clk,
   input logic               rst_n,
   input logic               period_end,
   input logic               sv_tick,
   input logic [UNB_W-1:0]   unbal,
   input logic [UNB_W-1:0]   unbal_limit,
   input logic [UNB_W-1:0]   redund_cap,
   input logic [DEPTH_W-1:0] depth,
   input logic               heavy_load,
   input logic [REG_W-1:0]   found_region,
   input logic               mode_sv,
   input logic               cfg_err,
   input logic               region_known,
   input logic [REG_W-1:0]   cur_region,
   input logic [NREG-1:0]    cand_mask
);
   assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !period_end |=> $stable(mode_sv));

   assert_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_sv && period_end && unbal > unbal_limit) |=> mode_sv);

   assert_stay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sv && unbal > unbal_limit) |=> mode_sv);

   assert_full_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !region_known |-> (&cand_mask));

   assert_four_cand_R9: assert property (@(posedge clk) disable iff (!rst_n)
      region_known |-> ($countones(cand_mask) == 4));

   assert_pwm_unknown_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_sv |-> !region_known);

   assert_keep_region_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sv_tick && mode_sv) |=> $stable(cur_region));
endmodule

bind modsel_supervisor modsel_supervisor_chk #(
   .UNB_W(UNB_W), .DEPTH_W(DEPTH_W), .REG_W(REG_W),
   .NREG(INNER_REGIONS + OUTER_REGIONS)
) u_chk (.*);

// File: tb/modsel_supervisor_test.sv
module modsel_supervisor_test;
   localparam int UNB_W = 8, DEPTH_W = 10, REG_W = 5, NREG = 18;
   localparam int RH = 172, RL = 197, LIM = 50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic period_end = 1'b0, sv_tick = 1'b0, heavy_load = 1'b0;
   logic [UNB_W-1:0] unbal = '0, unbal_limit = UNB_W'(LIM), redund_cap = 8'd20;
   logic [DEPTH_W-1:0] depth = '0;
   logic [REG_W-1:0] found_region = '0;
   logic mode_sv, cfg_err, region_known;
   logic [REG_W-1:0] cur_region;
   logic [NREG-1:0] cand_mask;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   modsel_supervisor uut (
      .clk(clk), .rst_n(rst_n), .period_end(period_end), .sv_tick(sv_tick),
      .unbal(unbal), .unbal_limit(unbal_limit), .redund_cap(redund_cap),
      .depth(depth), .heavy_load(heavy_load), .found_region(found_region),
      .mode_sv(mode_sv), .cfg_err(cfg_err), .region_known(region_known),
      .cur_region(cur_region), .cand_mask(cand_mask)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // advance one edge, then sit at the falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [NREG-1:0] model_mask(input int r);
      logic [NREG-1:0] m = '0;
      if (r <= 12) begin
         m[r-1] = 1'b1;
         m[r % 12] = 1'b1;
         m[12 + (r-1)/2] = 1'b1;
         m[12 + ((r+1)/2) % 6] = 1'b1;
      end else begin
         int j = r - 13;
         m[r-1] = 1'b1;
         m[12 + (j+1) % 6] = 1'b1;
         m[2*j+1] = 1'b1;
         m[(2*j+2) % 12] = 1'b1;
      end
      return m;
   endfunction

   task automatic force_mode(input bit sv);
      unbal = sv ? 8'd90 : 8'd0;
      depth = 10'd0;
      period_end = 1'b1;
      step();
      period_end = 1'b0;
   endtask

   task automatic set_region(input int r);
      sv_tick = 1'b1;
      found_region = 5'd0;
      step();
      found_region = REG_W'(r);
      step();
      sv_tick = 1'b0;
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 mode", mode_sv, 0);
      check("R1 known", region_known, 0);
      check("R1 cur", cur_region, 0);
      check("R1 mask", cand_mask, 18'h3ffff);

      // R7 configuration error
      for (int c = 0; c < 256; c += 5) begin
         redund_cap = UNB_W'(c);
         #1;
         check("R7 cfg_err", cfg_err, (LIM <= c) ? 1 : 0);
      end
      redund_cap = 8'd20;

      // R2..R6 mode sweep
      for (int start = 0; start < 2; start++)
         for (int h = 0; h < 2; h++)
            for (int d = 165; d <= 205; d++)
               for (int u = LIM - 1; u <= LIM + 1; u++) begin
                  bit exp_m;
                  force_mode(start[0]);
                  unbal = UNB_W'(u);
                  depth = DEPTH_W'(d);
                  heavy_load = h[0];
                  step();
                  check("R2 hold without strobe", mode_sv, start);
                  period_end = 1'b1;
                  step();
                  period_end = 1'b0;
                  if (start == 0) exp_m = (u > LIM);
                  else exp_m = !((u <= LIM) && (d <= (h ? RH : RL)));
                  if (start == 0) check("R3 entry", mode_sv, exp_m);
                  else if (u > LIM) check("R6 stay", mode_sv, exp_m);
                  else if (h == 1) check("R4 heavy return", mode_sv, exp_m);
                  else check("R5 light return", mode_sv, exp_m);
               end

      // R8..R10 region tracker sweep
      force_mode(1'b1);
      sv_tick = 1'b1;
      found_region = 5'd0;
      step();
      sv_tick = 1'b0;
      check("R8 unknown mask", cand_mask, 18'h3ffff);
      check("R10 invalid clears", region_known, 0);
      for (int c = 1; c <= NREG; c++)
         for (int f = 0; f <= 20; f++) begin
            bit hit;
            set_region(c);
            check("R10 load from unknown", cur_region, c);
            check("R9 neighbour mask", cand_mask, model_mask(c));
            hit = (f >= 1 && f <= NREG) && model_mask(c)[(f >= 1 && f <= NREG) ? f-1 : 0];
            sv_tick = 1'b1;
            found_region = REG_W'(f);
            step();
            sv_tick = 1'b0;
            check("R10 known", region_known, hit);
            check("R10 region", cur_region, hit ? f : c);
            if (!hit) check("R8 mask after miss", cand_mask, 18'h3ffff);
         end

      // R11 PWM ignores ticks and forgets the region
      set_region(5);
      force_mode(1'b0);
      check("R11 mode pwm", mode_sv, 0);
      check("R11 unknown in pwm", region_known, 0);
      sv_tick = 1'b1;
      found_region = 5'd9;
      step();
      step();
      sv_tick = 1'b0;
      check("R11 tick ignored", cur_region, 5);
      check("R11 mask full", cand_mask, 18'h3ffff);
      force_mode(1'b1);
      check("R11 still unknown after reentry", region_known, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule